// File: doc/BRIEF.md
# Graphic Panel Host Port with Display Memory

This block is the host side of a dot-matrix panel column controller. An 8-bit host drives a strobe, a read/write select, a data/command select and three chip selects. The block brings those pins into its own clock domain and acts on each falling strobe edge. It decodes the command set and holds a display memory of 8 pages by 64 columns, one byte per location. It keeps the page and column addresses, an output register that is filled ahead of time for reads, a busy window, a reset window, the display enable and the start line used for scrolling.

A second port lets the panel refresh engine read the memory at any time, and it does not disturb the host. A strap input turns the column order of that port around, so that one design fits panels mounted either way. The display enable and the start line are brought out for the refresh engine. The bus output enable tells the pad ring when to drive the data lines.

Top module: `glcd_host_port`

## Requirements
- R1: The block is selected only while cs1_n=0, cs2_n=0 and cs3=1. A strobe fall while not selected changes no state, and bus_oe stays low.
- R2: With cmd_n_data=1 and rd_n_wr=0, a falling strobe stores the data byte at (page, column) and then adds 1 to the column.
- R3: With cmd_n_data=1 and rd_n_wr=1, the bus returns the output register. The strobe fall then loads the byte at (page, column) into that register and adds 1 to the column. The first read after an address change therefore returns the earlier contents.
- R4: The column counts modulo 64, so 63 is followed by 0. The page never changes except through its own command.
- R5: With cmd_n_data=0 and rd_n_wr=0, the byte is a command. 0x3E and 0x3F clear and set the display enable (bit 0 = 1 means on). 01cccccc loads the column. 10111ppp loads the page. 11ssssss loads the start line. Any other code changes nothing.
- R6: With cmd_n_data=0 and rd_n_wr=1, the bus returns the status byte: bit 7 busy, bit 5 display off (1 = off), bit 4 reset in progress, and every other bit 0.
- R7: Every accepted operation other than a status read holds busy for BUSY_CYCLES clocks (default 2, range 1 to 3). A command that falls inside that window is dropped and changes no state.
- R8: Reset clears the display enable, the start line, the page, the column and the output register. The reset bit stays set for RESET_HOLD clocks (default 32) after release, and commands in that time are dropped.
- R9: bus_oe is high only while the synchronised strobe is high, the block is selected and rd_n_wr=1.
- R10: ref_data shows, one clock after the address is applied, the byte at page ref_page and column ref_col. When seg_flip=1 the column is 63-ref_col instead.
- R11: disp_on and start_line always equal the display enable and the start-line register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_e | input | 1 | Host strobe; writes and reads act on its falling edge |
| rd_n_wr | input | 1 | 1 = read, 0 = write |
| cmd_n_data | input | 1 | 1 = display data, 0 = command or status |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| bus_din | input | 8 | Data from the host |
| bus_dout | output | 8 | Data to the host |
| bus_oe | output | 1 | Drive enable for the data pads |
| seg_flip | input | 1 | Reverses the column order of the refresh port |
| ref_page | input | 3 | Refresh port page |
| ref_col | input | 6 | Refresh port segment index |
| ref_data | output | 8 | Refresh port data |
| disp_on | output | 1 | Display enable |
| start_line | output | 6 | Scroll start line |

## Verification
The assertions assume that the host pins come from a host slower than the system clock. They also assume that the select, direction and data lines stay still for at least two clocks around each strobe edge, so the synchronised copies agree at the edge that is detected. The bench drives every pin on the falling clock edge. It holds the strobe high for four clocks and low for eight in normal cycles. It shortens the gap only in the busy scenario, where one clock low and one clock high are enough to place the second strobe fall inside the busy window.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_DISP,
      CMD_COL,
      CMD_PAGE,
      CMD_START
   } cmd_e;

   function automatic cmd_e decode_cmd(input logic [7:0] code);
      cmd_e k;
      if (code[7:1] == 7'b0011111)      k = CMD_DISP;
      else if (code[7:6] == 2'b01)      k = CMD_COL;
      else if (code[7:3] == 5'b10111)   k = CMD_PAGE;
      else if (code[7:6] == 2'b11)      k = CMD_START;
      else                              k = CMD_NONE;
      return k;
   endfunction

endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync #(
   parameter int STAGES = 2,
   parameter int DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_in,
   input  logic          rw_in,
   input  logic          di_in,
   input  logic          sel_in,
   input  logic [DW-1:0] d_in,
   output logic          e_q,
   output logic          rw_q,
   output logic          di_q,
   output logic          sel_q,
   output logic [DW-1:0] d_q,
   output logic          e_fall
);
   localparam int W = DW + 4;

   initial begin
      if (STAGES < 2) $error("glcd_bus_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];
   logic         e_dly;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= {e_in, rw_in, di_in, sel_in, d_in};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign {e_q, rw_q, di_q, sel_q, d_q} = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_dly <= 1'b0;
      else        e_dly <= e_q;
   end

   assign e_fall = e_dly & ~e_q;

endmodule

// File: rtl/glcd_mem.sv
module glcd_mem #(
   parameter int PAGE_W  = 3,
   parameter int COL_W   = 6,
   parameter int DW      = 8,
   parameter bit REF_REG = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PAGE_W-1:0] h_page,
   input  logic [COL_W-1:0]  h_col,
   input  logic [DW-1:0]     h_wdata,
   output logic [DW-1:0]     h_rdata,
   input  logic [PAGE_W-1:0] r_page,
   input  logic [COL_W-1:0]  r_col,
   input  logic              r_flip,
   output logic [DW-1:0]     r_data
);
   localparam int AW    = PAGE_W + COL_W;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0]    store [DEPTH];
   logic [COL_W-1:0] r_col_eff;
   logic [AW-1:0]    r_addr;

   always_ff @(posedge clk) begin
      if (we) store[{h_page, h_col}] <= h_wdata;
   end

   assign h_rdata   = store[{h_page, h_col}];
   assign r_col_eff = r_flip ? ~r_col : r_col;
   assign r_addr    = {r_page, r_col_eff};

   generate
      if (REF_REG) begin : g_ref_reg
         always_ff @(posedge clk) r_data <= store[r_addr];
      end else begin : g_ref_comb
         assign r_data = store[r_addr];
      end
   endgenerate

endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
   import glcd_pkg::*;
#(
   parameter int PAGE_W      = 3,
   parameter int COL_W       = 6,
   parameter int DW          = 8,
   parameter int BUSY_CYCLES = 2,
   parameter int RESET_HOLD  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              sel,
   input  logic              rw,
   input  logic              di,
   input  logic [DW-1:0]     din,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_we,
   output logic [PAGE_W-1:0] page,
   output logic [COL_W-1:0]  col,
   output logic [DW-1:0]     out_reg,
   output logic [DW-1:0]     status,
   output logic              disp_en,
   output logic [COL_W-1:0]  start_ln
);
   localparam int BW = $clog2(BUSY_CYCLES + 1);
   localparam int HW = $clog2(RESET_HOLD + 1);

   initial begin
      if (BUSY_CYCLES < 1 || BUSY_CYCLES > 3) $error("glcd_ctrl: BUSY_CYCLES out of 1..3");
      if (RESET_HOLD < 1)                     $error("glcd_ctrl: RESET_HOLD must be positive");
      if (DW != 8)                            $error("glcd_ctrl: status layout needs DW of 8");
   end

   logic [BW-1:0] busy_cnt;
   logic [HW-1:0] hold_cnt;
   logic          busy, rst_flag, accept, is_status;
   cmd_e          kind;

   assign busy      = (busy_cnt != '0);
   assign rst_flag  = (hold_cnt != '0);
   assign is_status = ~di & rw;
   assign accept    = fall & sel & ~busy & ~rst_flag;
   assign kind      = decode_cmd(din);
   assign mem_we    = accept & di & ~rw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hold_cnt <= HW'(RESET_HOLD);
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_cnt <= '0;
      else if (accept && !is_status) busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy)              busy_cnt <= busy_cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page     <= '0;
         col      <= '0;
         out_reg  <= '0;
         disp_en  <= 1'b0;
         start_ln <= '0;
      end else if (accept) begin
         unique case ({di, rw})
            2'b10: col <= col + 1'b1;
            2'b11: begin
               out_reg <= mem_rdata;
               col     <= col + 1'b1;
            end
            2'b00: begin
               unique case (kind)
                  CMD_DISP:  disp_en  <= din[0];
                  CMD_COL:   col      <= din[COL_W-1:0];
                  CMD_PAGE:  page     <= din[PAGE_W-1:0];
                  CMD_START: start_ln <= din[COL_W-1:0];
                  default:   ;
               endcase
            end
            default: ;
         endcase
      end
   end

   assign status = {busy, 1'b0, ~disp_en, rst_flag, 4'b0000};

   p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BW'(BUSY_CYCLES));

   p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && di) |=> (col == $past(col) + 1'b1));

   p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && !di && !rw) |=> $stable(page));

   p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && busy) |=> ($stable(col) && $stable(page) && $stable(disp_en)
                          && $stable(start_ln) && $stable(out_reg)));

   p_desel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !sel) |=> ($stable(col) && $stable(page) && $stable(disp_en)
                          && $stable(start_ln) && $stable(out_reg)));

   p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_flag |-> (!disp_en && start_ln == '0));

endmodule

// File: rtl/glcd_host_port.sv
module glcd_host_port #(
   parameter int PAGE_W      = 3,
   parameter int COL_W       = 6,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 2,
   parameter int RESET_HOLD  = 32,
   parameter bit REF_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_e,
   input  logic              rd_n_wr,
   input  logic              cmd_n_data,
   input  logic              cs1_n,
   input  logic              cs2_n,
   input  logic              cs3,
   input  logic [DW-1:0]     bus_din,
   output logic [DW-1:0]     bus_dout,
   output logic              bus_oe,
   input  logic              seg_flip,
   input  logic [PAGE_W-1:0] ref_page,
   input  logic [COL_W-1:0]  ref_col,
   output logic [DW-1:0]     ref_data,
   output logic              disp_on,
   output logic [COL_W-1:0]  start_line
);
   logic              e_q, rw_q, di_q, sel_q, e_fall, mem_we;
   logic [DW-1:0]     d_q, mem_rdata, out_reg, status;
   logic [PAGE_W-1:0] page;
   logic [COL_W-1:0]  col;

   glcd_bus_sync #(.STAGES(SYNC_STAGES), .DW(DW)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .e_in(host_e), .rw_in(rd_n_wr), .di_in(cmd_n_data),
      .sel_in(~cs1_n & ~cs2_n & cs3), .d_in(bus_din),
      .e_q(e_q), .rw_q(rw_q), .di_q(di_q), .sel_q(sel_q), .d_q(d_q),
      .e_fall(e_fall)
   );

   glcd_ctrl #(.PAGE_W(PAGE_W), .COL_W(COL_W), .DW(DW),
               .BUSY_CYCLES(BUSY_CYCLES), .RESET_HOLD(RESET_HOLD)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fall(e_fall), .sel(sel_q), .rw(rw_q),
      .di(di_q), .din(d_q), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .page(page), .col(col), .out_reg(out_reg), .status(status),
      .disp_en(disp_on), .start_ln(start_line)
   );

   glcd_mem #(.PAGE_W(PAGE_W), .COL_W(COL_W), .DW(DW), .REF_REG(REF_REG)) u_mem (
      .clk(clk), .we(mem_we), .h_page(page), .h_col(col), .h_wdata(d_q),
      .h_rdata(mem_rdata), .r_page(ref_page), .r_col(ref_col),
      .r_flip(seg_flip), .r_data(ref_data)
   );

   assign bus_oe   = e_q & sel_q & rw_q;
   assign bus_dout = di_q ? out_reg : status;

   p_oe_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> !bus_oe);

endmodule

// File: tb/glcd_host_port_tb.sv
module glcd_host_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_e = 1'b0, rd_n_wr = 1'b0, cmd_n_data = 1'b0;
   logic       cs1_n = 1'b0, cs2_n = 1'b0, cs3 = 1'b1;
   logic [7:0] bus_din = '0;
   logic [7:0] bus_dout, ref_data;
   logic       bus_oe, disp_on, seg_flip = 1'b0;
   logic [2:0] ref_page = '0;
   logic [5:0] ref_col = '0, start_line;
   int         n_chk = 0, n_bad = 0;
   logic [7:0] rd;
   logic       oe_seen;

   always #5 clk = ~clk;

   glcd_host_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_e(host_e), .rd_n_wr(rd_n_wr),
      .cmd_n_data(cmd_n_data), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
      .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
      .seg_flip(seg_flip), .ref_page(ref_page), .ref_col(ref_col),
      .ref_data(ref_data), .disp_on(disp_on), .start_line(start_line)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_op(input logic r, input logic d, input logic [7:0] v);
      @(negedge clk);
      rd_n_wr = r; cmd_n_data = d; bus_din = v; host_e = 1'b1;
      repeat (4) @(negedge clk);
      rd = bus_dout; oe_seen = bus_oe;
      host_e = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic ref_rd(input logic [2:0] p, input logic [5:0] c, input logic f,
                         input string req, input logic [7:0] exp);
      @(negedge clk);
      ref_page = p; ref_col = c; seg_flip = f;
      @(negedge clk);
      chk(req, ref_data, exp);
   endtask

   task automatic t_reset;
      chk("R8 disp_on after reset", {7'b0, disp_on}, 8'h00);
      chk("R11 start_line after reset", {2'b0, start_line}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      bus_op(1'b0, 1'b0, 8'h3F);            // R8: dropped during hold
      bus_op(1'b1, 1'b0, 8'h00);
      chk("R8 R6 status during hold", rd, 8'h30);
      repeat (40) @(negedge clk);
      bus_op(1'b1, 1'b0, 8'h00);
      chk("R8 status after hold, on-command dropped", rd, 8'h20);
   endtask

   task automatic t_commands;
      bus_op(1'b0, 1'b0, 8'h3F);
      chk("R11 R5 disp_on after 0x3F", {7'b0, disp_on}, 8'h01);
      bus_op(1'b1, 1'b0, 8'h00);
      chk("R6 status display on", rd, 8'h00);
      chk("R9 oe during status read", {7'b0, oe_seen}, 8'h01);
      chk("R9 oe after strobe low", {7'b0, bus_oe}, 8'h00);
      bus_op(1'b0, 1'b0, 8'hC0 | 8'd45);
      chk("R5 R11 start line", {2'b0, start_line}, 8'd45);
      bus_op(1'b0, 1'b0, 8'h20);            // R5 unknown code
      chk("R5 unknown code ignored", {2'b0, start_line}, 8'd45);
   endtask

   task automatic t_write_read;
      bus_op(1'b0, 1'b0, 8'hB8 | 8'd3);
      bus_op(1'b0, 1'b0, 8'h40 | 8'd10);
      bus_op(1'b0, 1'b1, 8'hA5);
      bus_op(1'b0, 1'b1, 8'h3C);
      ref_rd(3'd3, 6'd10, 1'b0, "R2 R10 byte at col 10", 8'hA5);
      ref_rd(3'd3, 6'd11, 1'b0, "R2 R10 byte at col 11", 8'h3C);
      ref_rd(3'd3, 6'd53, 1'b1, "R10 flipped column", 8'hA5);
      bus_op(1'b0, 1'b0, 8'h40 | 8'd10);
      bus_op(1'b1, 1'b1, 8'h00);
      chk("R3 dummy read stale", rd, 8'h00);
      bus_op(1'b1, 1'b1, 8'h00);
      chk("R3 second read", rd, 8'hA5);
      bus_op(1'b1, 1'b1, 8'h00);
      chk("R3 third read", rd, 8'h3C);
   endtask

   task automatic t_wrap;
      bus_op(1'b0, 1'b0, 8'h40 | 8'd63);
      bus_op(1'b0, 1'b1, 8'h81);
      bus_op(1'b0, 1'b1, 8'h42);
      ref_rd(3'd3, 6'd63, 1'b0, "R4 last column", 8'h81);
      ref_rd(3'd3, 6'd0, 1'b0, "R4 wrap to col 0 same page", 8'h42);
   endtask

   task automatic t_deselect;
      bus_op(1'b0, 1'b1, 8'h11);            // lands at col 1, col -> 2
      @(negedge clk); cs3 = 1'b0;
      bus_op(1'b0, 1'b1, 8'hFF);
      bus_op(1'b1, 1'b0, 8'h00);
      chk("R1 R9 no oe when deselected", {7'b0, oe_seen}, 8'h00);
      @(negedge clk); cs3 = 1'b1; cs1_n = 1'b1;
      bus_op(1'b0, 1'b0, 8'h3E);
      chk("R1 cs1 high blocks command", {7'b0, disp_on}, 8'h01);
      @(negedge clk); cs1_n = 1'b0;
      bus_op(1'b0, 1'b1, 8'h22);
      ref_rd(3'd3, 6'd1, 1'b0, "R1 col 1 untouched", 8'h11);
      ref_rd(3'd3, 6'd2, 1'b0, "R1 column did not advance", 8'h22);
   endtask

   task automatic t_busy;
      // write 0x55 at col 3, then a status read inside the busy window
      @(negedge clk); rd_n_wr = 0; cmd_n_data = 1; bus_din = 8'h55; host_e = 1;
      repeat (4) @(negedge clk); host_e = 0;
      @(negedge clk); rd_n_wr = 1; cmd_n_data = 0; host_e = 1;
      @(negedge clk); host_e = 0;
      @(negedge clk);
      chk("R7 R6 busy bit set", bus_dout, 8'h80);
      repeat (8) @(negedge clk);
      chk("R7 busy cleared", bus_dout, 8'h00);
      // write 0x66 at col 4, then a column set inside the busy window
      @(negedge clk); rd_n_wr = 0; cmd_n_data = 1; bus_din = 8'h66; host_e = 1;
      repeat (4) @(negedge clk); host_e = 0;
      @(negedge clk); cmd_n_data = 0; bus_din = 8'h40 | 8'd20; host_e = 1;
      @(negedge clk); host_e = 0;
      repeat (8) @(negedge clk);
      bus_op(1'b0, 1'b1, 8'h77);
      ref_rd(3'd3, 6'd3, 1'b0, "R7 write before window", 8'h55);
      ref_rd(3'd3, 6'd5, 1'b0, "R7 column set dropped", 8'h77);
      bus_op(1'b0, 1'b0, 8'h3E);
      chk("R5 0x3E turns display off", {7'b0, disp_on}, 8'h00);
      bus_op(1'b1, 1'b0, 8'h00);
      chk("R6 status display off", rd, 8'h20);
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset;
      t_commands;
      t_write_read;
      t_wrap;
      t_deselect;
      t_busy;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule